// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block sits on the controller side of an external SDRAM interface. Software writes one 32-bit command word into it. The word names an operation, selects one or both attached devices, and carries a repeat count and a mode-register value. The sequencer turns the word into SDRAM control-pin activity and keeps a busy flag high while the operation and its timing gap are in progress. Software brings the memory up by writing a fixed series of words, waiting for busy to clear before each one:

1. enable the clock;
2. wait the power-up pause;
3. precharge all banks;
4. run two groups of four auto-refreshes;
5. load the mode register;
6. program the refresh interval.

A separate 32-bit refresh word loads a down-counting interval timer. Each time the timer expires, one auto-refresh request is raised for both devices. A request that arrives while the sequencer is occupied is held and issued as soon as the sequencer is idle. While the memory is in self-refresh or power-down, the timer is frozen and held requests wait. Exit from self-refresh uses a fixed delay.

Command word layout:

| Bits | Content |
|---|---|
| [2:0] | operation |
| 3 | selects device B |
| 4 | selects device A |
| [8:5] | repeat count minus one |
| [21:9] | mode-register value |

Operation codes: 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down, 7 reserved. The refresh word carries its interval count in bits [13:1].

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, busy is 0, CKE is 0, both chip selects are high (1) and RAS_n, CAS_n and WE_n are high.
- R2: A command word is taken only when busy is 0 at the clock edge. A word written while busy is 1, a word with both select bits (4 and 3) at 0, and a word with operation 7 are ignored.
- R3: For one cycle, the issue cycle drives these pins:

  | Operation | RAS_n | CAS_n | WE_n |
  |---|---|---|---|
  | Precharge-all (2) | 0 | 1 | 0 |
  | Auto-refresh (3) | 0 | 0 | 1 |
  | Load-mode (4) | 0 | 0 | 0 |
  | Self-refresh (5) | 0 | 0 | 1 |

  Chip select 0 goes low when word bit 4 is set, and chip select 1 goes low when word bit 3 is set. Operations 0, 1 and 6 leave all command pins high.
- R4: Precharge-all drives address bit 10 high and every other address bit low. Load-mode drives the address with word bits [21:9]. The bank pins are 0.
- R5: Auto-refresh issues (bits [8:5] + 1) refresh commands, from 1 to 16, spaced RC_CYC cycles apart. Busy stays high for RC_CYC cycles after the last one.
- R6: Busy rises in the cycle after acceptance and stays high for the operation's slot: RP_CYC for precharge, MRD_CYC for load-mode, RAS_CYC for self-refresh, and 1 for clock enable, power-down and a normal command outside low power.
- R7: Normal and clock enable raise CKE. Self-refresh and power-down lower it. The change is visible in the issue cycle.
- R8: A normal command given in self-refresh or power-down keeps busy high for XSR_CYC cycles with no command on the pins.
- R9: The refresh word loads its count N (bits [13:1]). While CKE is high, a refresh request is raised every N+1 cycles. N = 0 stops the timer.
- R10: A refresh request arriving while an operation runs is held, with busy high. It is issued to both devices as a single auto-refresh once the sequencer is idle, and it takes precedence over a software word.
- R11: While CKE is low, the interval timer does not advance, and a held request is neither issued nor shown on busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_word | input | 32 | Command word |
| rfsh_wr | input | 1 | Write strobe for the refresh word |
| rfsh_word | input | 32 | Refresh interval word, count in bits [13:1] |
| busy | output | 1 | Operation or live refresh request outstanding |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, index 0 is device A, index 1 is device B |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | ADDR_W | Address lines |
| sd_ba | output | 2 | Bank address |

## Verification
The hardest situation to reach is a timer expiry that lands while a long operation is already running, or while the memory is in self-refresh. It is equally hard to see the held request issued afterwards, exactly once and before any software word. The stimulus programs a 21-cycle interval and then starts a sixteen-refresh group lasting 112 cycles, so several expiries fall inside it. It later enters self-refresh with the timer still loaded, so a request can be captured at the entry edge and must wait out the exit delay. A behavioural model compares every pin and busy on every cycle through both sequences.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_CLKEN  = 3'd1,
    MD_PALL   = 3'd2,
    MD_AREF   = 3'd3,
    MD_LMR    = 3'd4,
    MD_SREF   = 3'd5,
    MD_PDOWN  = 3'd6,
    MD_RSVD   = 3'd7
  } sd_mode_e;

  localparam int F_DEVB    = 3;
  localparam int F_DEVA    = 4;
  localparam int F_REP_LSB = 5;
  localparam int REP_W     = 4;
  localparam int F_MRD_LSB = 9;
  localparam int NDEV      = 2;
endpackage

// File: rtl/sdseq_rtimer.sv
module sdseq_rtimer #(
  parameter int RT_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [RT_W-1:0] load_val,
  input  logic            run,
  input  logic            take,
  output logic            pend
);
  logic [RT_W-1:0] cnt_q, cnt_n, rel_q, rel_n;
  logic            en_q, en_n, pend_q, pend_n, fire;

  assign fire = en_q & run & ~load & (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    rel_n = rel_q;
    en_n  = en_q;
    if (load) begin
      rel_n = load_val;
      cnt_n = load_val;
      en_n  = |load_val;
    end else if (en_q & run) begin
      cnt_n = (cnt_q == '0) ? rel_q : cnt_q - 1'b1;
    end
    pend_n = fire | (pend_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rel_q  <= rel_n;
      en_q   <= en_n;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  // R11: counter frozen while the clock is gated off
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
  // R10: a request stays until it is consumed
  p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q);
endmodule

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int RC_CYC  = 7,
  parameter int RP_CYC  = 2,
  parameter int MRD_CYC = 2,
  parameter int XSR_CYC = 7,
  parameter int RAS_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic              pend,
  output logic              take,
  output logic              busy,
  output logic              cke,
  output logic              issue,
  output sd_mode_e          mode,
  output logic [NDEV-1:0]   mask,
  output logic [ADDR_W-1:0] mrd
);
  localparam int M1 = (RC_CYC > RP_CYC) ? RC_CYC : RP_CYC;
  localparam int M2 = (M1 > MRD_CYC) ? M1 : MRD_CYC;
  localparam int M3 = (M2 > XSR_CYC) ? M2 : XSR_CYC;
  localparam int SLOT_MAX = (M3 > RAS_CYC) ? M3 : RAS_CYC;
  localparam int GAP_W = $clog2(SLOT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_GAP} st_e;

  st_e              st_q, st_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic [REP_W-1:0] reps_q, reps_n;
  sd_mode_e         mode_q, mode_n, req_mode;
  logic [NDEV-1:0]  mask_q, mask_n, req_mask;
  logic [ADDR_W-1:0] mrd_q, mrd_n;
  logic             cke_q, cke_n, lp_q, lp_n;
  logic             idle, pend_live, acc, slot_end, ld_en;
  logic             unused_cmd;

  function automatic int slot_len(sd_mode_e m, logic lp);
    int v;
    case (m)
      MD_PALL:   v = RP_CYC;
      MD_AREF:   v = RC_CYC;
      MD_LMR:    v = MRD_CYC;
      MD_SREF:   v = RAS_CYC;
      MD_NORMAL: v = lp ? XSR_CYC : 1;
      default:   v = 1;
    endcase
    return (v < 1) ? 1 : v;
  endfunction

  assign unused_cmd = ^cmd_word[31:F_MRD_LSB+ADDR_W];
  assign req_mode   = sd_mode_e'(cmd_word[2:0]);
  assign req_mask   = {cmd_word[F_DEVB], cmd_word[F_DEVA]};
  assign idle       = (st_q == S_IDLE);
  assign pend_live  = pend & cke_q;
  assign take       = idle & pend_live;
  assign acc        = idle & ~pend_live & cmd_wr & (req_mask != '0) & (req_mode != MD_RSVD);
  assign ld_en      = take | acc;
  assign slot_end   = ((st_q == S_ISSUE) && (gap_q == '0)) ||
                      ((st_q == S_GAP) && (gap_q == GAP_W'(1)));

  always_comb begin
    st_n   = st_q;
    gap_n  = gap_q;
    reps_n = reps_q;
    mode_n = mode_q;
    mask_n = mask_q;
    mrd_n  = mrd_q;
    cke_n  = cke_q;
    lp_n   = lp_q;
    if (take) begin
      mode_n = MD_AREF;
      mask_n = '1;
      reps_n = '0;
      st_n   = S_ISSUE;
      gap_n  = GAP_W'(slot_len(MD_AREF, lp_q) - 1);
    end else if (acc) begin
      mode_n = req_mode;
      mask_n = req_mask;
      mrd_n  = cmd_word[F_MRD_LSB +: ADDR_W];
      reps_n = (req_mode == MD_AREF) ? cmd_word[F_REP_LSB +: REP_W] : '0;
      st_n   = S_ISSUE;
      gap_n  = GAP_W'(slot_len(req_mode, lp_q) - 1);
      case (req_mode)
        MD_NORMAL, MD_CLKEN: begin cke_n = 1'b1; lp_n = 1'b0; end
        MD_SREF, MD_PDOWN:   begin cke_n = 1'b0; lp_n = 1'b1; end
        default: ;
      endcase
    end else if (slot_end) begin
      if (reps_q != '0) begin
        reps_n = reps_q - 1'b1;
        st_n   = S_ISSUE;
        gap_n  = GAP_W'(slot_len(mode_q, lp_q) - 1);
      end else begin
        st_n = S_IDLE;
      end
    end else if (st_q == S_ISSUE) begin
      st_n = S_GAP;
    end else if (st_q == S_GAP) begin
      gap_n = gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      gap_q  <= '0;
      reps_q <= '0;
      cke_q  <= 1'b0;
      lp_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      gap_q  <= gap_n;
      reps_q <= reps_n;
      cke_q  <= cke_n;
      lp_q   <= lp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_NORMAL;
      mask_q <= '0;
      mrd_q  <= '0;
    end else if (ld_en) begin
      mode_q <= mode_n;
      mask_q <= mask_n;
      mrd_q  <= mrd_n;
    end
  end

  assign busy  = ~idle | pend_live;
  assign issue = (st_q == S_ISSUE);
  assign cke   = cke_q;
  assign mode  = mode_q;
  assign mask  = mask_q;
  assign mrd   = mrd_q;

  // R6: an accepted word shows as busy in the next cycle
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  // R5: a gap state always has cycles left to count
  p_gap_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_GAP) |-> (gap_q != '0));
  // R7: low-power state implies clock enable is low
  p_lp_cke_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_q |-> !cke_q);
endmodule

// File: rtl/sdseq_pins.sv
module sdseq_pins
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              issue,
  input  sd_mode_e          mode,
  input  logic [NDEV-1:0]   mask,
  input  logic [ADDR_W-1:0] mrd,
  output logic [NDEV-1:0]   cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba
);
  logic is_cmd;

  assign is_cmd = issue & (mode inside {MD_PALL, MD_AREF, MD_LMR, MD_SREF});

  for (genvar g = 0; g < NDEV; g++) begin : g_cs
    assign cs_n[g] = ~(is_cmd & mask[g]);
  end

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    if (issue) begin
      case (mode)
        MD_PALL: begin
          ras_n    = 1'b0;
          we_n     = 1'b0;
          addr[10] = 1'b1;
        end
        MD_AREF, MD_SREF: begin
          ras_n = 1'b0;
          cas_n = 1'b0;
        end
        MD_LMR: begin
          ras_n = 1'b0;
          cas_n = 1'b0;
          we_n  = 1'b0;
          addr  = mrd;
        end
        default: ;
      endcase
    end
  end

  assign ba = 2'b00;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int RT_W    = 13,
  parameter int RC_CYC  = 7,
  parameter int RP_CYC  = 2,
  parameter int MRD_CYC = 2,
  parameter int XSR_CYC = 7,
  parameter int RAS_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic              rfsh_wr,
  input  logic [31:0]       rfsh_word,
  output logic              busy,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [1:0]        sd_ba
);
  logic              pend, take, issue;
  sd_mode_e          mode;
  logic [NDEV-1:0]   mask;
  logic [ADDR_W-1:0] mrd;
  logic              unused_rfsh;

  assign unused_rfsh = ^{rfsh_word[31:RT_W+1], rfsh_word[0]};

  sdseq_rtimer #(.RT_W(RT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rfsh_wr),
    .load_val (rfsh_word[1 +: RT_W]),
    .run      (sd_cke),
    .take     (take),
    .pend     (pend)
  );

  sdseq_ctrl #(
    .ADDR_W (ADDR_W), .RC_CYC (RC_CYC), .RP_CYC (RP_CYC),
    .MRD_CYC(MRD_CYC), .XSR_CYC(XSR_CYC), .RAS_CYC(RAS_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_word (cmd_word),
    .pend     (pend),
    .take     (take),
    .busy     (busy),
    .cke      (sd_cke),
    .issue    (issue),
    .mode     (mode),
    .mask     (mask),
    .mrd      (mrd)
  );

  sdseq_pins #(.ADDR_W(ADDR_W)) u_pins (
    .issue (issue),
    .mode  (mode),
    .mask  (mask),
    .mrd   (mrd),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .addr  (sd_addr),
    .ba    (sd_ba)
  );

  // R3: deselected devices never see an active strobe
  p_nop_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&sd_cs_n) |-> (sd_ras_n && sd_cas_n && sd_we_n));
  // R10: a request raised by the timer survives a running operation
  p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && issue) |=> pend);
  // R11: a request is parked while the clock is gated off
  p_pend_lowpower_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !sd_cke) |=> pend);
endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int RC = 7, RP = 2, MRD = 2, XSR = 7, RAS = 4;

  logic clk, rst_n, cmd_wr, rfsh_wr;
  logic [31:0] cmd_word, rfsh_word;
  logic busy, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_cs_n, sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string phase = "R1";

  sdram_cmd_seq #(.ADDR_W(ADDR_W), .RC_CYC(RC), .RP_CYC(RP), .MRD_CYC(MRD),
                  .XSR_CYC(XSR), .RAS_CYC(RAS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .rfsh_wr(rfsh_wr), .rfsh_word(rfsh_word), .busy(busy), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_left, m_reps, m_mode, m_mask, m_mrd, m_issue, m_cke, m_lp;
  int m_tcnt, m_rel, m_ten, m_pend;

  function automatic int mslot(int md, int lp);
    case (md)
      2: return RP;
      3: return RC;
      4: return MRD;
      5: return RAS;
      0: return lp ? XSR : 1;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_left = 0; m_reps = 0; m_mode = 0; m_mask = 0; m_mrd = 0; m_issue = 0;
      m_cke = 0; m_lp = 0; m_tcnt = 0; m_rel = 0; m_ten = 0; m_pend = 0;
    end else begin
      int wm, wmask, oc, op;
      bit fire, take, acc;
      wm = int'(cmd_word[2:0]);
      wmask = int'({cmd_word[3], cmd_word[4]});
      oc = m_cke; op = m_pend;
      fire = (m_ten != 0) && (oc != 0) && !rfsh_wr && (m_tcnt == 0);
      take = (m_left == 0) && (op != 0) && (oc != 0);
      acc = (m_left == 0) && !((op != 0) && (oc != 0)) && cmd_wr && (wmask != 0) && (wm != 7);
      if (take) begin
        m_mode = 3; m_mask = 3; m_reps = 0; m_left = RC; m_issue = 1;
      end else if (acc) begin
        m_mode = wm; m_mask = wmask; m_mrd = int'(cmd_word[21:9]);
        m_reps = (wm == 3) ? int'(cmd_word[8:5]) : 0;
        m_left = mslot(wm, m_lp); m_issue = 1;
        if (wm == 0 || wm == 1) begin m_cke = 1; m_lp = 0; end
        if (wm == 5 || wm == 6) begin m_cke = 0; m_lp = 1; end
      end else if (m_left > 1) begin
        m_left--; m_issue = 0;
      end else if (m_left == 1) begin
        if (m_reps > 0) begin m_reps--; m_left = RC; m_issue = 1; end
        else begin m_left = 0; m_issue = 0; end
      end
      if (rfsh_wr) begin
        m_rel = int'(rfsh_word[13:1]); m_tcnt = m_rel; m_ten = (m_rel != 0);
      end else if (m_ten != 0 && oc != 0) begin
        m_tcnt = (m_tcnt == 0) ? m_rel : m_tcnt - 1;
      end
      m_pend = fire ? 1 : (take ? 0 : op);
    end
  end

  function automatic logic [21:0] expected();
    logic b, c, ra, ca, we, iscmd;
    logic [1:0] cs;
    logic [ADDR_W-1:0] ad;
    b = (m_left > 0) || (m_pend != 0 && m_cke != 0);
    c = (m_cke != 0);
    iscmd = (m_issue != 0) && (m_mode >= 2 && m_mode <= 5);
    cs[0] = !(iscmd && m_mask[0]);
    cs[1] = !(iscmd && m_mask[1]);
    ra = !iscmd;
    ca = !((m_issue != 0) && (m_mode == 3 || m_mode == 4 || m_mode == 5));
    we = !((m_issue != 0) && (m_mode == 2 || m_mode == 4));
    ad = '0;
    if (m_issue != 0 && m_mode == 2) ad[10] = 1'b1;
    if (m_issue != 0 && m_mode == 4) ad = m_mrd[ADDR_W-1:0];
    return {b, c, cs, ra, ca, we, ad, 2'b00};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [21:0] act, exp_v;
      act = {busy, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba};
      exp_v = expected();
      checks++;
      if (act !== exp_v) begin
        errors++;
        $display("FAIL %s cycle %0d model compare: actual=%h expected=%h", phase, cyc, act, exp_v);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic [31:0] mk(int md, bit a, bit b, int cnt, int mrd);
    return (32'(mrd) << 9) | (32'(cnt - 1) << 5) | (32'(a) << 4) | (32'(b) << 3) | 32'(md);
  endfunction

  task automatic send(input logic [31:0] w);
    cmd_word = w; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic load_timer(input int n);
    rfsh_word = 32'(n) << 1; rfsh_wr = 1'b1;
    @(negedge clk);
    rfsh_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      finish_sim();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int n, iss, t1, t2;
    rst_n = 1'b0; cmd_wr = 1'b0; rfsh_wr = 1'b0; cmd_word = '0; rfsh_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk(busy == 0 && sd_cke == 0, "R1 busy/cke after reset", {busy, sd_cke}, 0);
    chk(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n, "R1 pins idle", sd_cs_n, 3);

    phase = "R2";
    send(mk(2, 0, 0, 1, 0));
    chk(busy == 0, "R2 zero device mask ignored", busy, 0);
    send(mk(7, 1, 1, 1, 0));
    chk(busy == 0 && sd_cs_n == 2'b11, "R2 reserved code ignored", busy, 0);

    phase = "R7";
    send(mk(1, 1, 1, 1, 0));
    chk(sd_cke == 1 && busy == 1, "R7 clock enable raises cke", sd_cke, 1);
    wait_idle();
    repeat (40) @(negedge clk);

    phase = "R3";
    send(mk(2, 1, 1, 1, 0));
    chk(sd_cs_n == 2'b00 && !sd_ras_n && sd_cas_n && !sd_we_n, "R3 precharge pins",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b00010);
    chk(sd_addr == 13'h0400, "R4 precharge A10", sd_addr, 13'h400);
    n = 1;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    chk(n == RP, "R6 precharge slot length", n, RP);

    phase = "R5";
    send(mk(3, 1, 1, 4, 0));
    n = 0; iss = 0;
    while (busy) begin
      n++;
      if (sd_cs_n != 2'b11) iss++;
      @(negedge clk);
    end
    chk(n == 4 * RC, "R5 four refreshes busy span", n, 4 * RC);
    chk(iss == 4, "R5 refresh issue count", iss, 4);
    send(mk(3, 1, 1, 4, 0));
    wait_idle();

    phase = "R4";
    send(mk(4, 1, 1, 1, 12'h231));
    chk(sd_addr == 13'h231 && !sd_ras_n && !sd_cas_n && !sd_we_n && sd_ba == 0,
        "R4 load-mode address", sd_addr, 13'h231);
    wait_idle();

    phase = "R3";
    send(mk(2, 1, 0, 1, 0));
    chk(sd_cs_n == 2'b10, "R3 device A only", sd_cs_n, 2);
    wait_idle();
    send(mk(2, 0, 1, 1, 0));
    chk(sd_cs_n == 2'b01, "R3 device B only", sd_cs_n, 1);
    wait_idle();

    phase = "R2";
    send(mk(3, 1, 1, 2, 0));
    send(mk(2, 1, 1, 1, 0));
    wait_idle();
    iss = 0;
    repeat (6) begin if (sd_cs_n != 2'b11) iss++; @(negedge clk); end
    chk(iss == 0, "R2 word during busy ignored", iss, 0);

    phase = "R9";
    load_timer(20);
    while (sd_cs_n == 2'b11) @(negedge clk);
    t1 = cyc;
    while (sd_cs_n != 2'b11) @(negedge clk);
    while (sd_cs_n == 2'b11) @(negedge clk);
    t2 = cyc;
    chk(t2 - t1 == 21, "R9 refresh interval", t2 - t1, 21);

    phase = "R10";
    wait_idle();
    send(mk(3, 1, 1, 16, 0));
    iss = 0;
    while (busy) begin
      if (sd_cs_n != 2'b11) iss++;
      @(negedge clk);
    end
    chk(iss >= 17, "R10 deferred refresh after long group", iss, 17);

    phase = "R11";
    wait_idle();
    send(mk(5, 1, 1, 1, 0));
    chk(sd_cke == 0 && sd_cs_n == 2'b00 && !sd_ras_n && !sd_cas_n && sd_we_n,
        "R11 self-refresh entry pins", {sd_cke, sd_cs_n}, 0);
    wait_idle();
    iss = 0;
    repeat (100) begin if (sd_cs_n != 2'b11 || busy) iss++; @(negedge clk); end
    chk(iss == 0, "R11 no refresh while cke low", iss, 0);

    phase = "R8";
    send(mk(0, 1, 1, 1, 0));
    chk(sd_cke == 1, "R8 normal raises cke", sd_cke, 1);
    n = 0;
    repeat (XSR) begin
      if (busy && sd_cs_n == 2'b11) n++;
      @(negedge clk);
    end
    chk(n == XSR, "R8 exit delay busy without command", n, XSR);
    wait_idle();

    phase = "R9";
    load_timer(0);
    wait_idle();
    iss = 0;
    repeat (60) begin if (sd_cs_n != 2'b11) iss++; @(negedge clk); end
    chk(iss == 0, "R9 zero count stops timer", iss, 0);

    phase = "R7";
    send(mk(6, 1, 1, 1, 0));
    chk(sd_cke == 0 && sd_cs_n == 2'b11, "R7 power-down lowers cke", sd_cke, 0);
    wait_idle();
    send(mk(1, 1, 1, 1, 0));
    chk(sd_cke == 1, "R7 clock enable restores cke", sd_cke, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule